// File: doc/BRIEF.md
# Key-Protected Clock and Power Controller

This special-function-register block sits on a small microcontroller's register bus and gates every change to the power control register behind a key. Software first writes the key byte to the key register. The very next register write may then update the power control register. Any other write in between, or a different key byte, locks the register again. A second key value does not touch power control. Instead it produces a one-cycle unlock pulse for the timekeeping register group, which sits outside this block.

From the 4.096 MHz system clock, the block makes two clock enables. The core enable fires once every 2^N system cycles, where N is the three-bit divider field. This gives 4.096 MHz down to 32 kHz. A new divider value is taken only when the current core period ends, so the core never sees a shortened period. The metering enable fires once every five system cycles (819.2 kHz) and does not depend on the divider.

The block also watches the PLL lock input. When lock is lost, it raises a core reset request and sets a sticky fault flag in a status register. That flag clears only when software writes the acknowledge bit.

Top module: `clkpwr_ctl`

## Requirements
- R1: After reset, the power control register at address 0xC5 reads 0x82 (divider field = 2, bit 7 = 1, all other bits 0). meter_off, core_off and core_rst_req are low, and the fault flag reads 0.
- R2: A write to 0xC5 is applied only if the immediately preceding SFR write put 0xA7 into the key register at 0xC1. Otherwise the write is ignored.
- R3: The key unlock is used up by the next SFR write of any kind. A key write of any value other than 0xA7, or a write to any other address, leaves the power control register locked.
- R4: Writing 0xEA to 0xC1 drives rtc_unlock high for exactly the one cycle after the write. This does not unlock the power control register.
- R5: core_ce is high for one system cycle in every 2^N cycles, where N is bits [2:0] of the power control register (code 0 gives every cycle, code 7 gives one in 128).
- R6: A new divider value takes effect only at the end of the current core period. Every gap between two core_ce pulses is therefore a full old period or a full new period.
- R7: meter_ce is high for one system cycle in every five, whatever the divider setting.
- R8: Bit 6 of the power control register drives meter_off and bit 4 drives core_off.
- R9: The key register reads 0x00. In the power control register, bit 7 always reads 1, bits 5 and 3 always read 0, and writes to these three bits are ignored.
- R10: While pll_locked is low, core_rst_req is high from the following cycle. Bit 4 of the status register at 0xF4 is set in that cycle and stays set after lock returns.
- R11: Writing a 1 in bit 0 of address 0xD8 clears the fault flag, but only while lock is present. Other bits at 0xD8 have no effect, and 0xD8 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.096 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_wdata | input | 8 | SFR write data |
| sfr_we | input | 1 | SFR write strobe, one cycle per write |
| sfr_rdata | output | 8 | SFR read data for sfr_addr (combinational) |
| pll_locked | input | 1 | PLL lock indication, high when locked |
| core_ce | output | 1 | Core clock enable, one pulse per core period |
| meter_ce | output | 1 | Metering clock enable, one pulse per five cycles |
| meter_off | output | 1 | Turns off the metering circuitry |
| core_off | output | 1 | Core shutdown request for the low-power mode |
| core_rst_req | output | 1 | Core reset request while lock is lost |
| rtc_unlock | output | 1 | One-cycle unlock pulse for the timekeeping registers |

## Verification
The bench attacks the key sequence with an intervening write to another address, a wrong key byte and the timekeeping key. A design that keeps the unlock armed across other writes, or that accepts either key, would let the later power write through. The bench also switches the divider from the slowest code to a fast one partway through a period. A design that loads the new code at once would produce a short gap instead of completing the 128-cycle period. Finally, it acknowledges the fault while lock is still missing, and it writes the wrong bit of the acknowledge register. A flag that clears on any write, or that loses its set priority, would read 0 where the bench expects 0x10.

// File: rtl/clkpwr_pkg.sv
package clkpwr_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;
    localparam int SEL_W  = 3;

    localparam logic [ADDR_W-1:0] ADDR_KEY  = 8'hC1;
    localparam logic [ADDR_W-1:0] ADDR_PWR  = 8'hC5;
    localparam logic [ADDR_W-1:0] ADDR_ACK  = 8'hD8;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 8'hF4;

    localparam logic [DATA_W-1:0] KEY_PWR = 8'hA7;
    localparam logic [DATA_W-1:0] KEY_RTC = 8'hEA;
    localparam logic [DATA_W-1:0] PWR_RST = 8'h82;

    localparam int FAULT_BIT = 4;
    localparam int ACK_BIT   = 0;
    localparam int METER_DIV = 5;

    typedef struct packed {
        logic             rsv7;
        logic             meter_off;
        logic             rsv5;
        logic             core_off;
        logic             rsv3;
        logic [SEL_W-1:0] div_sel;
    } pwr_ctrl_t;

    typedef enum logic [0:0] {
        KEY_LOCKED = 1'b0,
        KEY_ARMED  = 1'b1
    } key_state_t;

    // Writable fields come from the bus; reserved bits keep their reset value
    function automatic pwr_ctrl_t apply_write(input logic [DATA_W-1:0] wd);
        pwr_ctrl_t r;
        r           = pwr_ctrl_t'(PWR_RST);
        r.meter_off = wd[6];
        r.core_off  = wd[4];
        r.div_sel   = wd[SEL_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/clkpwr_key_gate.sv
module clkpwr_key_gate
    import clkpwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output pwr_ctrl_t         ctrl,
    output logic              rtc_pulse
);

    key_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= KEY_LOCKED;
            ctrl      <= pwr_ctrl_t'(PWR_RST);
            rtc_pulse <= 1'b0;
        end else begin
            rtc_pulse <= 1'b0;
            if (we) begin
                if (addr == ADDR_KEY) begin
                    st        <= (wdata == KEY_PWR) ? KEY_ARMED : KEY_LOCKED;
                    rtc_pulse <= (wdata == KEY_RTC);
                end else begin
                    if (addr == ADDR_PWR && st == KEY_ARMED) begin
                        ctrl <= apply_write(wdata);
                    end
                    st <= KEY_LOCKED;
                end
            end
        end
    end

endmodule

// File: rtl/clkpwr_core_div.sv
module clkpwr_core_div #(
    parameter int               SEL_W   = 3,
    parameter logic [SEL_W-1:0] RST_SEL = 3'd2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_req,
    output logic             ce
);

    localparam int MAX_DIV = 1 << ((1 << SEL_W) - 1);
    localparam int CNT_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

    logic [SEL_W-1:0] sel_act;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    always_comb last = CNT_W'((32'd1 << sel_act) - 32'd1);

    // New ratio is taken only when the running period completes
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            sel_act <= RST_SEL;
        end else if (cnt == last) begin
            cnt     <= '0;
            sel_act <= sel_req;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ce = (cnt == '0);

endmodule

// File: rtl/clkpwr_meter_div.sv
module clkpwr_meter_div #(
    parameter int DIV = 5
) (
    input  logic clk,
    input  logic rst,
    output logic ce
);

    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || cnt == CNT_W'(DIV - 1)) cnt <= '0;
        else                               cnt <= cnt + 1'b1;
    end

    assign ce = (cnt == '0);

endmodule

// File: rtl/clkpwr_fault_trk.sv
module clkpwr_fault_trk (
    input  logic clk,
    input  logic rst,
    input  logic pll_locked,
    input  logic ack,
    output logic fault,
    output logic rst_req
);

    // Loss of lock wins over a same-cycle acknowledge
    always_ff @(posedge clk) begin
        if (rst) begin
            fault   <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= ~pll_locked;
            if (!pll_locked) fault <= 1'b1;
            else if (ack)    fault <= 1'b0;
        end
    end

endmodule

// File: rtl/clkpwr_ctl.sv
module clkpwr_ctl
    import clkpwr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  sfr_addr,
    input  logic [7:0]  sfr_wdata,
    input  logic        sfr_we,
    output logic [7:0]  sfr_rdata,
    input  logic        pll_locked,
    output logic        core_ce,
    output logic        meter_ce,
    output logic        meter_off,
    output logic        core_off,
    output logic        core_rst_req,
    output logic        rtc_unlock
);

    pwr_ctrl_t ctrl;
    logic      fault;
    logic      ack;

    assign ack = sfr_we && (sfr_addr == ADDR_ACK) && sfr_wdata[ACK_BIT];

    clkpwr_key_gate u_key (
        .clk       (clk),
        .rst       (rst),
        .we        (sfr_we),
        .addr      (sfr_addr),
        .wdata     (sfr_wdata),
        .ctrl      (ctrl),
        .rtc_pulse (rtc_unlock)
    );

    clkpwr_core_div #(
        .SEL_W   (SEL_W),
        .RST_SEL (PWR_RST[SEL_W-1:0])
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .sel_req (ctrl.div_sel),
        .ce      (core_ce)
    );

    clkpwr_meter_div #(.DIV(METER_DIV)) u_meter (
        .clk (clk),
        .rst (rst),
        .ce  (meter_ce)
    );

    clkpwr_fault_trk u_fault (
        .clk        (clk),
        .rst        (rst),
        .pll_locked (pll_locked),
        .ack        (ack),
        .fault      (fault),
        .rst_req    (core_rst_req)
    );

    assign meter_off = ctrl.meter_off;
    assign core_off  = ctrl.core_off;

    always_comb begin
        sfr_rdata = '0;
        case (sfr_addr)
            ADDR_PWR:  sfr_rdata = ctrl;
            ADDR_STAT: sfr_rdata[FAULT_BIT] = fault;
            default:   sfr_rdata = '0;
        endcase
    end

endmodule

// File: rtl/clkpwr_ctl_chk.sv
module clkpwr_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] sfr_addr,
    input logic [7:0] sfr_wdata,
    input logic       sfr_we,
    input logic       pll_locked,
    input logic       core_ce,
    input logic       meter_ce,
    input logic       meter_off,
    input logic       core_off,
    input logic       core_rst_req,
    input logic       rtc_unlock
);

    logic       armed;
    logic [7:0] gcnt;
    logic [7:0] gap;
    logic       gseen;
    logic [2:0] mcnt;
    logic       mseen;

    assign gap = gcnt + 8'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            gcnt  <= '0;
            gseen <= 1'b0;
            mcnt  <= '0;
            mseen <= 1'b0;
        end else begin
            if (sfr_we) armed <= (sfr_addr == 8'hC1) && (sfr_wdata == 8'hA7);
            if (core_ce) begin
                gcnt  <= '0;
                gseen <= 1'b1;
            end else if (gcnt != 8'hFF) begin
                gcnt <= gcnt + 8'd1;
            end
            if (meter_ce) begin
                mcnt  <= '0;
                mseen <= 1'b1;
            end else if (mcnt != 3'd7) begin
                mcnt <= mcnt + 3'd1;
            end
        end
    end

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sfr_we && sfr_addr == 8'hC5 && !armed) |=> ($stable(meter_off) && $stable(core_off))); // R2

    AST_RTC_SOURCE: assert property (@(posedge clk) disable iff (rst)
        rtc_unlock |-> $past(sfr_we && sfr_addr == 8'hC1 && sfr_wdata == 8'hEA)); // R4

    AST_RTC_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        rtc_unlock |=> !rtc_unlock); // R4

    AST_CORE_GAP_POW2: assert property (@(posedge clk) disable iff (rst)
        (core_ce && gseen) |-> ($countones(gap) == 1 && gap <= 8'd128)); // R6

    AST_METER_GAP: assert property (@(posedge clk) disable iff (rst)
        (meter_ce && mseen) |-> (mcnt == 3'd4)); // R7

    AST_LOCK_LOSS_RESET: assert property (@(posedge clk) disable iff (rst)
        !pll_locked |=> core_rst_req); // R10

endmodule

bind clkpwr_ctl clkpwr_ctl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .sfr_addr     (sfr_addr),
    .sfr_wdata    (sfr_wdata),
    .sfr_we       (sfr_we),
    .pll_locked   (pll_locked),
    .core_ce      (core_ce),
    .meter_ce     (meter_ce),
    .meter_off    (meter_off),
    .core_off     (core_off),
    .core_rst_req (core_rst_req),
    .rtc_unlock   (rtc_unlock)
);

// File: tb/clkpwr_ctl_bench.sv
`timescale 1ns/1ps
module clkpwr_ctl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] sfr_addr = '0;
    logic [7:0] sfr_wdata = '0;
    logic       sfr_we = 1'b0;
    logic [7:0] sfr_rdata;
    logic       pll_locked = 1'b1;
    logic       core_ce, meter_ce, meter_off, core_off, core_rst_req, rtc_unlock;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int mon_last = 0;
    bit mon_have = 0;
    bit done = 0;
    int exp_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    clkpwr_ctl u_clkpwr_ctl (
        .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .pll_locked(pll_locked),
        .core_ce(core_ce), .meter_ce(meter_ce), .meter_off(meter_off),
        .core_off(core_off), .core_rst_req(core_rst_req), .rtc_unlock(rtc_unlock)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
        @(negedge clk);
        sfr_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        sfr_addr = a;
        #1;
        v = int'(sfr_rdata);
    endtask

    task automatic set_div(input int code);
        wr(8'hC1, 8'hA7);
        wr(8'hC5, 8'(code));
        repeat (2) @(negedge clk iff core_ce);
        @(posedge clk);
        repeat (3) exp_q.push_back(1 << code);
        wait (exp_q.size() == 0);
    endtask

    // Monitor: compares each measured core period against the scoreboard
    always @(negedge clk) begin
        if (!rst && core_ce) begin
            if (mon_have && exp_q.size() > 0)
                check("R5 core period", cyc - mon_last, exp_q.pop_front());
            mon_last = cyc;
            mon_have = 1;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v;
        int prev;
        int cnt;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(8'hC5, v); check("R1 ctrl reset", v, 'h82);
        rd(8'hF4, v); check("R1 fault reset", v, 0);
        check("R1 meter_off reset", meter_off, 0);
        check("R1 core_off reset", core_off, 0);
        check("R1 rst_req reset", core_rst_req, 0);
        rd(8'hC1, v); check("R9 key reads zero", v, 0);

        wr(8'hC5, 8'h50);
        rd(8'hC5, v); check("R2 write without key", v, 'h82);
        check("R2 meter_off unchanged", meter_off, 0);

        wr(8'hC1, 8'hA7); wr(8'hC5, 8'h53);
        rd(8'hC5, v); check("R2 keyed write", v, 'hD3);
        check("R8 meter_off set", meter_off, 1);
        check("R8 core_off set", core_off, 1);

        wr(8'hC1, 8'hA7); wr(8'hC5, 8'h28);
        rd(8'hC5, v); check("R9 reserved bits", v, 'h80);

        wr(8'hC1, 8'hA7); wr(8'h80, 8'h90); wr(8'hC5, 8'h47);
        rd(8'hC5, v); check("R3 other write relocks", v, 'h80);
        wr(8'hC1, 8'hA7); wr(8'hC1, 8'h11); wr(8'hC5, 8'h47);
        rd(8'hC5, v); check("R3 wrong key relocks", v, 'h80);
        wr(8'hC1, 8'hA7); wr(8'hC5, 8'h42); wr(8'hC5, 8'h13);
        rd(8'hC5, v); check("R3 unlock used once", v, 'hC2);

        wr(8'hC1, 8'hEA);
        check("R4 rtc pulse high", rtc_unlock, 1);
        @(negedge clk);
        check("R4 rtc pulse one cycle", rtc_unlock, 0);
        wr(8'hC5, 8'h47);
        rd(8'hC5, v); check("R4 rtc key no power unlock", v, 'hC2);
        wr(8'hC1, 8'hA7);
        check("R4 power key no rtc pulse", rtc_unlock, 0);
        wr(8'h00, 8'h00);

        set_div(0); set_div(1); set_div(2); set_div(5); set_div(3); set_div(7);

        // R6: switch mid-period from 128 to 2
        @(negedge clk);
        prev = mon_last;
        wr(8'hC1, 8'hA7); wr(8'hC5, 8'h01);
        @(negedge clk iff core_ce);
        check("R6 old period completes", cyc - prev, 128);
        prev = cyc;
        @(negedge clk iff core_ce);
        check("R6 new period after switch", cyc - prev, 2);

        cnt = 0;
        repeat (100) begin
            @(negedge clk);
            if (meter_ce) cnt++;
        end
        check("R7 meter pulses per 100", cnt, 20);
        @(negedge clk iff meter_ce); prev = cyc;
        @(negedge clk iff meter_ce);
        check("R7 meter gap", cyc - prev, 5);

        pll_locked = 1'b0;
        @(negedge clk);
        check("R10 rst_req on loss", core_rst_req, 1);
        rd(8'hF4, v); check("R10 fault set", v, 'h10);
        wr(8'hD8, 8'h01);
        rd(8'hF4, v); check("R11 ack ignored while unlocked", v, 'h10);
        pll_locked = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R10 rst_req drops", core_rst_req, 0);
        rd(8'hF4, v); check("R10 fault sticky", v, 'h10);
        wr(8'hD8, 8'h02);
        rd(8'hF4, v); check("R11 wrong bit no clear", v, 'h10);
        rd(8'hD8, v); check("R11 ack reg reads zero", v, 0);
        wr(8'hD8, 8'h01);
        rd(8'hF4, v); check("R11 ack clears", v, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule